// File: doc/BRIEF.md
# Random Word Fetch Controller with Seed-Error Retry

This block serves a request for a given number of random bytes by driving a register-bus port into a hardware random generator. It reads the generator's status register until a bit is set and reads one data word whenever the status shows only the ready flag. It streams that word out one byte at a time on a valid/ready byte interface. When the generator reports a seed error, the block hands control to an external concealment sequencer over a start/done/fail handshake. A seed error is reported either by the seed-error flag in the status or by an all-zero data word. After the handshake the block goes back to polling.

The block counts consecutive recovery attempts, and any good data word resets that count. The request is abandoned as unrecoverable when the sequencer reports failure or when the count goes past the configured limit. A clock-error flag on its own does not stop the block. It raises a one-cycle warning, writes zero to the status register and carries on. Each request ends with a one-cycle completion pulse and a result code.

Top module: `rngf_fetch`

## Requirements
- R1: Out of reset, and whenever no request is active, the block is idle: `req_busy`, `bus_req`, `out_valid`, `conc_start` and `done` are all low.
- R2: While polling, the block reads the status register (`bus_we`=0, `bus_addr`=`SR_ADDR`) and holds each request until `bus_ack`. If every status read returns zero for `POLL_TIMEOUT` cycles after polling began, the request ends with `done_code`=2 (timeout) and no bytes are emitted.
- R3: A status value equal to the ready flag alone (bit `RDY_BIT`, default bit 0) causes exactly one read of the data register (`bus_addr`=`DR_ADDR`).
- R4: A status value that is not ready-alone and has the seed-error flag set (bit `SEED_ERR_BIT`, default bit 6) produces a one-cycle `conc_start` and no slow-clock warning. After `conc_done` without `conc_fail`, polling resumes and the request can still finish with code 1.
- R5: If `conc_fail` is high together with `conc_done`, the request ends with `done_code`=3 (unrecoverable).
- R6: A concealment that raises the consecutive count above `MAX_TRIES` (default 3, so the fourth in a row) ends the request with `done_code`=3 once its `conc_done` arrives.
- R7: Every nonzero data word resets the consecutive count, so runs of up to `MAX_TRIES` concealments separated by good words never abort.
- R8: A status value with the clock-error flag (bit `CLK_ERR_BIT`, default bit 5) and without the seed-error flag gives a one-cycle `slow_clk_warn` and one bus write of zero to `SR_ADDR`. No concealment starts and polling resumes.
- R9: A data word of zero is treated as a late seed error and takes the same concealment and counting path as R4 to R6. None of its bytes are emitted.
- R10: From each good word the block emits min(remaining, `DATA_W`/8) bytes, least-significant byte first. `out_last` is high only on the final byte of the request.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold and `out_valid` stays high.
- R12: `done` is a one-cycle pulse with a nonzero `done_code` (1 = ok, 2 = timeout, 3 = unrecoverable). A request for zero bytes completes with code 1 and no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Starts a request (sampled while idle) |
| req_bytes | input | CNT_W | Number of bytes requested |
| req_busy | output | 1 | A request is in progress |
| bus_req | output | 1 | Register access pending |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data (always zero) |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Completes the pending access |
| conc_start | output | 1 | One-cycle start of the concealment sequence |
| conc_done | input | 1 | Concealment sequence finished |
| conc_fail | input | 1 | Concealment failed, valid with conc_done |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the request |
| slow_clk_warn | output | 1 | One-cycle clock-error warning |
| done | output | 1 | One-cycle request completion |
| done_code | output | 2 | 1 ok, 2 timeout, 3 unrecoverable |

## Verification
The bench builds the block with `POLL_TIMEOUT` cut to 40 cycles. At that value the no-data timeout path completes after about twenty zero-status reads instead of thousands of cycles. `MAX_TRIES` stays at its default of 3, so a run of four back-to-back concealments, from status flags or from zero words, is enough to show the abort. A run of three, a good word, then three more shows the counter reset. `DATA_W` stays at 32, so requests of one to eight bytes cover full words, a partial final word and two-word requests. These requests are run both with a consumer that is always ready and with one that stalls every third cycle.

// File: rtl/rngf_pkg.sv
package rngf_pkg;

   typedef enum logic [1:0] {
      RES_NONE    = 2'd0,
      RES_OK      = 2'd1,
      RES_TIMEOUT = 2'd2,
      RES_UNRECOV = 2'd3
   } rngf_result_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL,
      ST_CLR,
      ST_DATA,
      ST_CONC,
      ST_EMIT,
      ST_DONE
   } rngf_state_e;

endpackage

// File: rtl/rngf_poll_timer.sv
module rngf_poll_timer #(
   parameter int LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt_q;

   assign expired = (cnt_q >= W'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run && !expired) begin
         cnt_q <= cnt_q + W'(1);
      end
   end
endmodule

// File: rtl/rngf_try_ctr.sv
module rngf_try_ctr #(
   parameter int MAX = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic over
);
   localparam int W = $clog2(MAX + 2);

   logic [W-1:0] cnt_q;

   assign over = (cnt_q > W'(MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc && !over) begin
         cnt_q <= cnt_q + W'(1);
      end
   end
endmodule

// File: rtl/rngf_byte_emit.sv
module rngf_byte_emit #(
   parameter int DATA_W = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                load,
   input  logic [DATA_W-1:0]                   word,
   input  logic [$clog2(DATA_W/8 + 1)-1:0]     nbytes,
   input  logic                                ready,
   output logic                                valid,
   output logic [7:0]                          data,
   output logic                                drained
);
   localparam int BYTES  = DATA_W / 8;
   localparam int IDX_W  = $clog2(BYTES);
   localparam int LANE_W = $clog2(BYTES + 1);

   logic [DATA_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LANE_W-1:0] left_q;
   logic [7:0]        lane [BYTES];

   for (genvar gi = 0; gi < BYTES; gi++) begin : g_lane
      assign lane[gi] = word_q[8*gi +: 8];
   end

   assign valid   = (left_q != '0);
   assign data    = lane[idx_q];
   assign drained = valid && ready && (left_q == LANE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
         left_q <= '0;
      end else if (load) begin
         word_q <= word;
         idx_q  <= '0;
         left_q <= nbytes;
      end else if (valid && ready) begin
         idx_q  <= idx_q + IDX_W'(1);
         left_q <= left_q - LANE_W'(1);
      end
   end
endmodule

// File: rtl/rngf_fetch.sv
module rngf_fetch
   import rngf_pkg::*;
#(
   parameter int                DATA_W       = 32,
   parameter int                CNT_W        = 16,
   parameter int                ADDR_W       = 4,
   parameter logic [ADDR_W-1:0] SR_ADDR      = 4'h4,
   parameter logic [ADDR_W-1:0] DR_ADDR      = 4'h8,
   parameter int                RDY_BIT      = 0,
   parameter int                CLK_ERR_BIT  = 5,
   parameter int                SEED_ERR_BIT = 6,
   parameter int                POLL_TIMEOUT = 10000,
   parameter int                MAX_TRIES    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [CNT_W-1:0]  req_bytes,
   output logic              req_busy,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              conc_start,
   input  logic              conc_done,
   input  logic              conc_fail,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic              slow_clk_warn,
   output logic              done,
   output logic [1:0]        done_code
);
   localparam int                BYTES    = DATA_W / 8;
   localparam int                LANE_W   = $clog2(BYTES + 1);
   localparam logic [DATA_W-1:0] RDY_ONLY = DATA_W'(1) << RDY_BIT;

   // elaboration-time parameter checks
   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_width
      $error("rngf_fetch: DATA_W must be a multiple of 8 and at least 16");
   end
   if (CNT_W <= LANE_W) begin : g_bad_cnt
      $error("rngf_fetch: CNT_W too small for the per-word byte count");
   end
   if (RDY_BIT >= DATA_W || CLK_ERR_BIT >= DATA_W || SEED_ERR_BIT >= DATA_W) begin : g_bad_bit
      $error("rngf_fetch: status bit position outside the word");
   end
   if (RDY_BIT == CLK_ERR_BIT || RDY_BIT == SEED_ERR_BIT || CLK_ERR_BIT == SEED_ERR_BIT) begin : g_dup_bit
      $error("rngf_fetch: status bit positions must differ");
   end
   if (SR_ADDR == DR_ADDR) begin : g_dup_addr
      $error("rngf_fetch: status and data addresses must differ");
   end
   if (POLL_TIMEOUT < 1 || MAX_TRIES < 1) begin : g_bad_limits
      $error("rngf_fetch: POLL_TIMEOUT and MAX_TRIES must be positive");
   end

   rngf_state_e       st_q, st_d;
   rngf_result_e      code_q, code_d;
   logic [CNT_W-1:0]  remain_q, remain_d;
   logic              conc_q, conc_d;
   logic              warn_q, warn_d;

   logic              try_clr, try_inc, try_over;
   logic              tmr_restart, tmr_expired, poll_again;
   logic              em_load, em_valid, em_drained;
   logic [LANE_W-1:0] em_nbytes;
   logic [7:0]        em_data;

   rngf_poll_timer #(.LIMIT(POLL_TIMEOUT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tmr_restart),
      .run     (st_q == ST_POLL),
      .expired (tmr_expired)
   );

   rngf_try_ctr #(.MAX(MAX_TRIES)) u_tries (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (try_clr),
      .inc   (try_inc),
      .over  (try_over)
   );

   rngf_byte_emit #(.DATA_W(DATA_W)) u_emit (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (em_load),
      .word    (bus_rdata),
      .nbytes  (em_nbytes),
      .ready   (out_ready),
      .valid   (em_valid),
      .data    (em_data),
      .drained (em_drained)
   );

   assign tmr_restart = (st_q != ST_POLL) || poll_again;
   assign em_nbytes   = (remain_q >= CNT_W'(BYTES)) ? LANE_W'(BYTES) : remain_q[LANE_W-1:0];

   always_comb begin
      st_d       = st_q;
      code_d     = code_q;
      remain_d   = remain_q;
      conc_d     = 1'b0;
      warn_d     = 1'b0;
      try_clr    = 1'b0;
      try_inc    = 1'b0;
      em_load    = 1'b0;
      poll_again = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_start) begin
               try_clr = 1'b1;
               if (req_bytes == '0) begin
                  code_d = RES_OK;
                  st_d   = ST_DONE;
               end else begin
                  code_d   = RES_NONE;
                  remain_d = req_bytes;
                  st_d     = ST_POLL;
               end
            end
         end
         ST_POLL: begin
            if (bus_ack) begin
               if (bus_rdata == '0) begin
                  if (tmr_expired) begin
                     code_d = RES_TIMEOUT;
                     st_d   = ST_DONE;
                  end
               end else if (bus_rdata == RDY_ONLY) begin
                  st_d = ST_DATA;
               end else if (bus_rdata[SEED_ERR_BIT]) begin
                  conc_d  = 1'b1;
                  try_inc = 1'b1;
                  st_d    = ST_CONC;
               end else if (bus_rdata[CLK_ERR_BIT]) begin
                  warn_d = 1'b1;
                  st_d   = ST_CLR;
               end else begin
                  poll_again = 1'b1;
               end
            end
         end
         ST_CLR: begin
            if (bus_ack) st_d = ST_POLL;
         end
         ST_DATA: begin
            if (bus_ack) begin
               if (bus_rdata == '0) begin
                  conc_d  = 1'b1;
                  try_inc = 1'b1;
                  st_d    = ST_CONC;
               end else begin
                  em_load = 1'b1;
                  try_clr = 1'b1;
                  st_d    = ST_EMIT;
               end
            end
         end
         ST_CONC: begin
            if (conc_done && !conc_q) begin
               if (conc_fail || try_over) begin
                  code_d = RES_UNRECOV;
                  st_d   = ST_DONE;
               end else begin
                  st_d = ST_POLL;
               end
            end
         end
         ST_EMIT: begin
            if (em_valid && out_ready) remain_d = remain_q - CNT_W'(1);
            if (em_drained) begin
               if (remain_q == CNT_W'(1)) begin
                  code_d = RES_OK;
                  st_d   = ST_DONE;
               end else begin
                  st_d = ST_POLL;
               end
            end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         code_q   <= RES_NONE;
         remain_q <= '0;
         conc_q   <= 1'b0;
         warn_q   <= 1'b0;
      end else begin
         st_q     <= st_d;
         code_q   <= code_d;
         remain_q <= remain_d;
         conc_q   <= conc_d;
         warn_q   <= warn_d;
      end
   end

   assign req_busy      = (st_q != ST_IDLE);
   assign bus_req       = (st_q == ST_POLL) || (st_q == ST_CLR) || (st_q == ST_DATA);
   assign bus_we        = (st_q == ST_CLR);
   assign bus_addr      = (st_q == ST_DATA) ? DR_ADDR : SR_ADDR;
   assign bus_wdata     = '0;
   assign conc_start    = conc_q;
   assign slow_clk_warn = warn_q;
   assign out_valid     = em_valid && (st_q == ST_EMIT);
   assign out_data      = em_data;
   assign out_last      = out_valid && (remain_q == CNT_W'(1));
   assign done          = (st_q == ST_DONE);
   assign done_code     = code_q;
endmodule

// File: rtl/rngf_fetch_chk.sv
module rngf_fetch_chk #(
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 4,
   parameter logic [ADDR_W-1:0] SR_ADDR = 4'h4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_busy,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic              conc_start,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic              out_last,
   input logic              slow_clk_warn,
   input logic              done,
   input logic [1:0]        done_code
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_busy |-> (!bus_req && !out_valid && !conc_start && !done));

   p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

   p_conc_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conc_start |=> !conc_start);

   p_conc_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conc_start |-> (!bus_req && !out_valid && !slow_clk_warn));

   p_clear_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we |-> (bus_wdata == '0) && (bus_addr == SR_ADDR));

   p_warn_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slow_clk_warn |=> !slow_clk_warn);

   p_emit_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !bus_req);

   p_last_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid);

   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_code != 2'd0));
endmodule

bind rngf_fetch rngf_fetch_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .SR_ADDR (SR_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_busy      (req_busy),
   .bus_req       (bus_req),
   .bus_we        (bus_we),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .bus_ack       (bus_ack),
   .conc_start    (conc_start),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_data      (out_data),
   .out_last      (out_last),
   .slow_clk_warn (slow_clk_warn),
   .done          (done),
   .done_code     (done_code)
);

// File: tb/sim_rngf_fetch.sv
module sim_rngf_fetch;
   localparam int             DW  = 32;
   localparam int             CW  = 16;
   localparam int             AW  = 4;
   localparam logic [AW-1:0]  SRA = 4'h4;
   localparam logic [AW-1:0]  DRA = 4'h8;
   localparam logic [31:0]    RDY = 32'h01;
   localparam logic [31:0]    CEF = 32'h20;
   localparam logic [31:0]    SEF = 32'h40;

   typedef struct packed {
      logic [7:0]  nb;
      logic [31:0] w0;
      logic [31:0] w1;
      logic        stall;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'd4, 32'h44332211, 32'h0,        1'b0},
      '{8'd1, 32'hA5C3E17F, 32'h0,        1'b0},
      '{8'd6, 32'h04030201, 32'h0C0B0A09, 1'b0},
      '{8'd8, 32'h89ABCDEF, 32'h01234567, 1'b1},
      '{8'd3, 32'hDEADBEEF, 32'h0,        1'b1},
      '{8'd5, 32'h55667788, 32'h99AABBCC, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic [CW-1:0] req_bytes = '0;
   logic          req_busy;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;
   logic          bus_ack = 1'b0;
   logic          conc_start;
   logic          conc_done = 1'b0;
   logic          conc_fail = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [7:0]    out_data;
   logic          out_last;
   logic          slow_clk_warn;
   logic          done;
   logic [1:0]    done_code;

   always #5 clk = ~clk;

   rngf_fetch #(.POLL_TIMEOUT(40)) u0 (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_bytes(req_bytes),
      .req_busy(req_busy), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .conc_start(conc_start), .conc_done(conc_done), .conc_fail(conc_fail),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .slow_clk_warn(slow_clk_warn), .done(done),
      .done_code(done_code)
   );

   // scripted register responses and observed activity
   logic [31:0] sr_s [16];
   logic [31:0] dr_s [16];
   int sr_n, sr_p, dr_n, dr_p;
   int n_sr, n_dr, n_wr, n_badwr, n_conc, n_warn, n_out, conc_wait, cyc;
   logic [7:0] got [16];
   logic       got_last [16];
   logic       done_seen, stall;
   logic [1:0] got_code;
   int n_chk = 0, n_bad = 0;
   bit ended = 0;

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_scripts();
      sr_n = 0; dr_n = 0; conc_fail = 1'b0; stall = 1'b0;
   endtask

   task automatic push_sr(input logic [31:0] v);
      sr_s[sr_n] = v; sr_n++;
   endtask

   task automatic push_dr(input logic [31:0] v);
      dr_s[dr_n] = v; dr_n++;
   endtask

   task automatic run_req(input int nb);
      @(negedge clk);
      sr_p = 0; dr_p = 0; n_sr = 0; n_dr = 0; n_wr = 0; n_badwr = 0;
      n_conc = 0; n_warn = 0; n_out = 0; conc_wait = 0;
      done_seen = 1'b0; got_code = 2'd0;
      req_bytes = CW'(nb);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
      if (!done_seen) check(1'b0, "watchdog on request", 32'd0, 32'd1);
   endtask

   // bus slave, concealment responder and output monitor, all at the falling edge
   initial begin
      cyc = 0; conc_wait = 0; stall = 1'b0; done_seen = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         conc_done = 1'b0;
         if (conc_wait > 0) begin
            conc_wait--;
            if (conc_wait == 0) conc_done = 1'b1;
         end
         if (conc_start) begin
            n_conc++;
            conc_wait = 2;
         end
         if (bus_req && !bus_ack) begin
            bus_ack = 1'b1;
            if (bus_we) begin
               n_wr++;
               if (bus_wdata != '0 || bus_addr != SRA) n_badwr++;
               bus_rdata = '0;
            end else if (bus_addr == DRA) begin
               n_dr++;
               bus_rdata = (dr_p < dr_n) ? dr_s[dr_p] : 32'hCAFEF00D;
               dr_p++;
            end else begin
               n_sr++;
               bus_rdata = (sr_p < sr_n) ? sr_s[sr_p] : 32'h0;
               sr_p++;
            end
         end else begin
            bus_ack = 1'b0;
         end
         if (slow_clk_warn) n_warn++;
         out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
         if (out_valid && out_ready) begin
            if (n_out < 16) begin
               got[n_out]      = out_data;
               got_last[n_out] = out_last;
            end
            n_out++;
         end
         if (done) begin
            done_seen = 1'b1;
            got_code  = done_code;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL global watchdog: actual 0 expected 1");
      finish_run();
   end

   initial begin
      clear_scripts();
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!req_busy && !bus_req && !out_valid && !done && !conc_start,
            "R1 reset idle", {req_busy, bus_req, out_valid, done, conc_start}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!req_busy && !bus_req, "R1 idle after reset", {req_busy, bus_req}, 32'd0);

      // table of clean requests: R3 R10 R11 R12
      for (int v = 0; v < 6; v++) begin
         int nb;
         int nw;
         clear_scripts();
         nb = int'(VECS[v].nb);
         nw = (nb + 3) / 4;
         for (int w = 0; w < nw; w++) begin
            push_sr(RDY);
            push_dr(w == 0 ? VECS[v].w0 : VECS[v].w1);
         end
         stall = VECS[v].stall;
         run_req(nb);
         check(got_code == 2'd1, "R12 ok code", got_code, 1);
         check(n_out == nb, "R10 byte count", n_out, nb);
         check(n_dr == nw, "R3 one data read per word", n_dr, nw);
         for (int k = 0; k < nb; k++) begin
            logic [31:0] wsel;
            logic [7:0]  eb;
            wsel = (k < 4) ? VECS[v].w0 : VECS[v].w1;
            eb   = wsel[8*(k%4) +: 8];
            check(got[k] == eb, "R10 R11 byte value", got[k], eb);
            check(got_last[k] == (k == nb - 1), "R10 last flag", got_last[k], (k == nb - 1));
         end
      end

      // R12: zero-byte request
      clear_scripts();
      run_req(0);
      check(got_code == 2'd1, "R12 zero request code", got_code, 1);
      check(n_sr + n_dr + n_wr == 0, "R12 zero request no bus", n_sr + n_dr + n_wr, 0);

      // R2: status never sets a bit
      clear_scripts();
      run_req(4);
      check(got_code == 2'd2, "R2 timeout code", got_code, 2);
      check(n_out == 0, "R2 no bytes on timeout", n_out, 0);
      check(n_sr > 5, "R2 repeated status reads", n_sr, 6);

      // R4: seed error with clock error also set, then data
      clear_scripts();
      push_sr(SEF | CEF); push_sr(RDY); push_dr(32'h12345678);
      run_req(4);
      check(n_conc == 1, "R4 one concealment", n_conc, 1);
      check(n_warn == 0, "R4 no warning with seed error", n_warn, 0);
      check(got_code == 2'd1, "R4 recovered code", got_code, 1);
      check(n_out == 4 && got[0] == 8'h78, "R4 data after recovery", got[0], 32'h78);

      // R5: concealment reports failure
      clear_scripts();
      push_sr(SEF); push_sr(RDY); push_dr(32'h11111111);
      conc_fail = 1'b1;
      run_req(4);
      check(got_code == 2'd3, "R5 unrecoverable code", got_code, 3);
      check(n_out == 0, "R5 no bytes", n_out, 0);

      // R6: four back-to-back seed errors
      clear_scripts();
      for (int i = 0; i < 4; i++) push_sr(SEF);
      push_sr(RDY); push_dr(32'h22222222);
      run_req(4);
      check(n_conc == 4, "R6 concealments before abort", n_conc, 4);
      check(got_code == 2'd3, "R6 abort code", got_code, 3);

      // R7: good word between runs of three resets the count
      clear_scripts();
      for (int i = 0; i < 3; i++) push_sr(SEF);
      push_sr(RDY);
      for (int i = 0; i < 3; i++) push_sr(SEF);
      push_sr(RDY);
      push_dr(32'hA1A2A3A4); push_dr(32'hB1B2B3B4);
      run_req(8);
      check(n_conc == 6, "R7 concealments", n_conc, 6);
      check(got_code == 2'd1, "R7 completes ok", got_code, 1);
      check(n_out == 8 && got[4] == 8'hB4, "R7 second word", got[4], 32'hB4);

      // R8: clock error only
      clear_scripts();
      push_sr(CEF); push_sr(RDY); push_dr(32'h0000BEEF);
      run_req(2);
      check(n_warn == 1, "R8 one warning", n_warn, 1);
      check(n_wr == 1 && n_badwr == 0, "R8 single zero write to status", n_wr, 1);
      check(n_conc == 0, "R8 no concealment", n_conc, 0);
      check(got_code == 2'd1 && got[1] == 8'hBE, "R8 data still used", got[1], 32'hBE);

      // R9: zero data word then good word
      clear_scripts();
      push_sr(RDY); push_sr(RDY); push_dr(32'h0); push_dr(32'hF00DFACE);
      run_req(4);
      check(n_conc == 1, "R9 zero word conceals", n_conc, 1);
      check(n_out == 4 && got[0] == 8'hCE, "R9 zero word not emitted", got[0], 32'hCE);
      check(got_code == 2'd1, "R9 completes ok", got_code, 1);

      // R9 with R6: four zero words in a row
      clear_scripts();
      for (int i = 0; i < 4; i++) begin push_sr(RDY); push_dr(32'h0); end
      run_req(4);
      check(n_conc == 4 && got_code == 2'd3, "R9 zero words exhaust tries", got_code, 3);

      repeat (3) @(negedge clk);
      check(!req_busy && !bus_req, "R1 idle at end", {req_busy, bus_req}, 32'd0);
      finish_run();
   end
endmodule